// File: doc/BRIEF.md
# MSI Vector Capture Controller

This block sits beside the inbound write path of a PCIe root port and turns message-signalled interrupt writes into pending bits. Every inbound memory write is compared against one 64-bit capture address held in two 32-bit registers. A write that hits that address is taken by the block. Its data word is the global vector number. Vector v sets bit v%32 of group v/32, and there are 8 groups of 32 bits. A write that misses the address is passed on unchanged in the same cycle.

Each group has three registers on a simple 32-bit register bus: an enable word, a mask word and a status word. The status word is cleared by writing a 1 to a bit. A single aggregate interrupt level goes toward the CPU, and a one-cycle pulse marks each of its rising edges for an edge-sensitive interrupt input. Software normally uses only 32-bit capture addresses and leaves the upper address register at zero.

Top module: `msi_capture_ctrl`

## Requirements
- R1: After reset every register reads zero, and irq_o, irq_edge_o and fwd_valid_o are low.
- R2: The capture address low word is at offset 0x820 and the high word is at 0x824. Both read back what was written. Any offset that holds no register reads zero.
- R3: A write with wr_addr_i equal to {high,low} and wr_data_i below 256 sets status bit wr_data_i%32 of group wr_data_i/32 at the next clock edge, but only when the matching enable bit is 1.
- R4: Group g's status word is at 0x830+12*g. Writing 1 to a bit clears it, and writing 0 leaves the bit unchanged.
- R5: When a capture and a clear hit the same status bit in the same cycle, the bit ends set.
- R6: Group g's enable word is at 0x828+12*g and its mask word is at 0x82C+12*g. Both read back what was written.
- R7: irq_o is high one clock edge after the status holds any bit whose mask bit is 0, and low one edge after no such bit remains. irq_edge_o is high for exactly the first cycle of each high period of irq_o.
- R8: A write that hits the capture address with wr_data_i of 256 or more changes no status bit and is not forwarded.
- R9: A write that misses the capture address appears on fwd_valid_o, fwd_addr_o and fwd_data_o in the same cycle, unchanged, and sets no status bit. A write that hits is never forwarded.
- R10: A captured bit whose mask bit is 1 is held in status but does not raise irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Inbound memory write valid |
| wr_addr_i | input | 64 | Inbound write address |
| wr_data_i | input | 32 | Inbound write data |
| reg_wr_i | input | 1 | Register bus write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| fwd_valid_o | output | 1 | Missed write forwarded |
| fwd_addr_o | output | 64 | Forwarded write address |
| fwd_data_o | output | 32 | Forwarded write data |
| irq_o | output | 1 | Aggregate interrupt level |
| irq_edge_o | output | 1 | One-cycle pulse on each rising edge of irq_o |

## Verification
If the vector decode is wrong, the error shows on the register bus one clock after a capture: the bit appears in the wrong group or at the wrong position, or a disabled or out-of-range vector appears at all. If the enable, mask or clear path is wrong, irq_o and irq_edge_o are wrong exactly two edges after the stimulus. If the address compare is wrong, fwd_valid_o is wrong in the same cycle as the write. The directed tests sample every one of these ports at the cycle where its change is due. They also cover the lowest and highest vectors, a capture and a clear in the same cycle, and an address that differs only in its upper word.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;
  localparam int unsigned DEF_NUM_GROUPS = 8;
  localparam int unsigned DEF_GROUP_W    = 32;
  localparam int unsigned DEF_REG_AW     = 12;
  // register offsets (bytes)
  localparam int unsigned OFS_ADDR_LO  = 32'h820;
  localparam int unsigned OFS_ADDR_HI  = 32'h824;
  localparam int unsigned OFS_GRP_BASE = 32'h828;
  localparam int unsigned GRP_STRIDE   = 12;
  localparam int unsigned OFS_EN       = 0;
  localparam int unsigned OFS_MASK     = 4;
  localparam int unsigned OFS_STAT     = 8;
endpackage

// File: rtl/msi_addr_match.sv
module msi_addr_match
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = DEF_NUM_GROUPS,
  parameter int unsigned GROUP_W    = DEF_GROUP_W,
  parameter int unsigned REG_AW     = DEF_REG_AW,
  localparam int unsigned VEC_N     = NUM_GROUPS * GROUP_W,
  localparam int unsigned VEC_W     = $clog2(VEC_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [63:0]       wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       rdata_o,
  output logic [VEC_N-1:0]  hit_vec_o,
  output logic              fwd_valid_o
);
  localparam logic [REG_AW-1:0] ADR_LO = REG_AW'(OFS_ADDR_LO);
  localparam logic [REG_AW-1:0] ADR_HI = REG_AW'(OFS_ADDR_HI);

  logic [31:0] lo_q, hi_q;
  logic        addr_hit, in_range;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (reg_wr_i) begin
      if (reg_addr_i == ADR_LO) lo_q <= reg_wdata_i;
      if (reg_addr_i == ADR_HI) hi_q <= reg_wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (reg_addr_i == ADR_LO) rdata_o = lo_q;
    if (reg_addr_i == ADR_HI) rdata_o = hi_q;
  end

  assign addr_hit    = wr_valid_i && (wr_addr_i == {hi_q, lo_q});
  assign in_range    = (wr_data_i >> VEC_W) == '0;
  assign fwd_valid_o = wr_valid_i && !addr_hit;

  always_comb begin
    hit_vec_o = '0;
    if (addr_hit && in_range) hit_vec_o = VEC_N'(1) << wr_data_i[VEC_W-1:0];
  end

  assert_out_of_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_data_i >= VEC_N) |-> (hit_vec_o == '0));
  assert_single_vector_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_o));
endmodule

// File: rtl/msi_group_bank.sv
module msi_group_bank
  import msi_cap_pkg::*;
#(
  parameter int unsigned GROUP_W = DEF_GROUP_W,
  parameter int unsigned REG_AW  = DEF_REG_AW,
  parameter logic [REG_AW-1:0] BASE = REG_AW'(OFS_GRP_BASE)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [REG_AW-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  input  logic [GROUP_W-1:0] set_i,
  output logic [31:0]        rdata_o,
  output logic               pend_o
);
  localparam logic [REG_AW-1:0] ADR_EN   = BASE + REG_AW'(OFS_EN);
  localparam logic [REG_AW-1:0] ADR_MASK = BASE + REG_AW'(OFS_MASK);
  localparam logic [REG_AW-1:0] ADR_STAT = BASE + REG_AW'(OFS_STAT);

  logic [GROUP_W-1:0] en_q, mask_q, stat_q;
  logic [GROUP_W-1:0] clr_w, set_eff;

  assign clr_w   = (reg_wr_i && reg_addr_i == ADR_STAT) ? reg_wdata_i[GROUP_W-1:0] : '0;
  assign set_eff = set_i & en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (reg_wr_i && reg_addr_i == ADR_EN)   en_q   <= reg_wdata_i[GROUP_W-1:0];
      if (reg_wr_i && reg_addr_i == ADR_MASK) mask_q <= reg_wdata_i[GROUP_W-1:0];
      stat_q <= (stat_q & ~clr_w) | set_eff;  // capture wins over clear
    end
  end

  always_comb begin
    rdata_o = '0;
    if (reg_addr_i == ADR_EN)   rdata_o = 32'(en_q);
    if (reg_addr_i == ADR_MASK) rdata_o = 32'(mask_q);
    if (reg_addr_i == ADR_STAT) rdata_o = 32'(stat_q);
  end

  assign pend_o = |(stat_q & ~mask_q);

  assert_set_needs_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));
  assert_w1c_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & $past(clr_w & ~set_i)) == '0));
  assert_capture_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q & $past(set_i & en_q)) == $past(set_i & en_q)));
endmodule

// File: rtl/msi_irq_agg.sv
module msi_irq_agg
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = DEF_NUM_GROUPS
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_GROUPS-1:0] pend_i,
  output logic                  irq_o,
  output logic                  irq_edge_o
);
  logic irq_q, irq_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      irq_d <= 1'b0;
    end else begin
      irq_q <= |pend_i;
      irq_d <= irq_q;
    end
  end

  assign irq_o      = irq_q;
  assign irq_edge_o = irq_q && !irq_d;

  assert_edge_with_level_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_edge_o |-> irq_o);
  assert_rise_has_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|pend_i));
endmodule

// File: rtl/msi_capture_ctrl.sv
module msi_capture_ctrl
  import msi_cap_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = DEF_NUM_GROUPS,
  parameter int unsigned GROUP_W    = DEF_GROUP_W,
  parameter int unsigned REG_AW     = DEF_REG_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [63:0]       wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  output logic              fwd_valid_o,
  output logic [63:0]       fwd_addr_o,
  output logic [31:0]       fwd_data_o,
  output logic              irq_o,
  output logic              irq_edge_o
);
  localparam int unsigned VEC_N = NUM_GROUPS * GROUP_W;

  logic [VEC_N-1:0]      hit_vec;
  logic [31:0]           addr_rdata;
  logic [31:0]           grp_rdata [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] grp_pend;

  msi_addr_match #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W), .REG_AW(REG_AW)) u_match (
    .clk_i, .rst_ni, .wr_valid_i, .wr_addr_i, .wr_data_i,
    .reg_wr_i, .reg_addr_i, .reg_wdata_i,
    .rdata_o(addr_rdata), .hit_vec_o(hit_vec), .fwd_valid_o(fwd_valid_o)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
    localparam logic [REG_AW-1:0] GB = REG_AW'(OFS_GRP_BASE + g * GRP_STRIDE);
    msi_group_bank #(.GROUP_W(GROUP_W), .REG_AW(REG_AW), .BASE(GB)) u_bank (
      .clk_i, .rst_ni, .reg_wr_i, .reg_addr_i, .reg_wdata_i,
      .set_i(hit_vec[g*GROUP_W +: GROUP_W]),
      .rdata_o(grp_rdata[g]), .pend_o(grp_pend[g])
    );
  end

  always_comb begin
    reg_rdata_o = addr_rdata;
    for (int g = 0; g < NUM_GROUPS; g++) reg_rdata_o |= grp_rdata[g];
  end

  msi_irq_agg #(.NUM_GROUPS(NUM_GROUPS)) u_irq (
    .clk_i, .rst_ni, .pend_i(grp_pend), .irq_o, .irq_edge_o
  );

  assign fwd_addr_o = wr_addr_i;
  assign fwd_data_o = wr_data_i;

  assert_hit_not_fwd_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> (hit_vec == '0));
endmodule

// File: tb/msi_capture_ctrl_bench.sv
module msi_capture_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_valid_i = 1'b0;
  logic [63:0] wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        fwd_valid_o;
  logic [63:0] fwd_addr_o;
  logic [31:0] fwd_data_o;
  logic        irq_o, irq_edge_o;

  int checks = 0;
  int errors = 0;
  localparam logic [63:0] TGT = 64'h0000_0000_A000_0000;

  always #10 clk = ~clk;

  msi_capture_ctrl u_msi_capture_ctrl (
    .clk_i(clk), .rst_ni, .wr_valid_i, .wr_addr_i, .wr_data_i,
    .reg_wr_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .fwd_valid_o, .fwd_addr_o, .fwd_data_o, .irq_o, .irq_edge_o
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr_i = a;
    #1 chk(reg_rdata_o == exp, tag, 64'(reg_rdata_o), 64'(exp));
  endtask

  task automatic msi(input logic [63:0] a, input logic [31:0] d, output bit fv,
                     output logic [63:0] fa, output logic [31:0] fd);
    @(negedge clk);
    wr_valid_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    #1 fv = fwd_valid_o; fa = fwd_addr_o; fd = fwd_data_o;
    @(negedge clk);
    wr_valid_i = 1'b0;
  endtask

  task automatic t_reset();
    #1 chk(irq_o == 0 && irq_edge_o == 0 && fwd_valid_o == 0, "R1 outputs", {61'd0, irq_o, irq_edge_o, fwd_valid_o}, 0);
    reg_chk(12'h820, 0, "R1 addr lo");
    reg_chk(12'h824, 0, "R1 addr hi");
    reg_chk(12'h828, 0, "R1 enable0");
    reg_chk(12'h884, 0, "R1 status7");
  endtask

  task automatic t_config();
    reg_wr(12'h820, TGT[31:0]);
    reg_wr(12'h824, TGT[63:32]);
    reg_chk(12'h820, TGT[31:0], "R2 addr lo");
    reg_chk(12'h824, 32'h0, "R2 addr hi");
    reg_chk(12'h900, 32'h0, "R2 unused 0x900");
    reg_chk(12'h81C, 32'h0, "R2 unused 0x81C");
    for (int g = 0; g < 8; g++)
      reg_wr(12'(32'h828 + 12 * g), (g == 2) ? 32'h0 : 32'hFFFF_FFFF);
    reg_wr(12'h82C + 12'd12, 32'hFFFF_FFFF);
    reg_chk(12'h828 + 12'd84, 32'hFFFF_FFFF, "R6 enable7");
    reg_chk(12'h828 + 12'd24, 32'h0, "R6 enable2");
    reg_chk(12'h82C + 12'd12, 32'hFFFF_FFFF, "R6 mask1");
    reg_chk(12'h82C, 32'h0, "R6 mask0");
  endtask

  task automatic t_capture();
    bit fv; logic [63:0] fa; logic [31:0] fd;
    msi(TGT, 32'd5, fv, fa, fd);
    chk(fv == 0, "R9 hit not forwarded", 64'(fv), 0);
    #1 chk(irq_o == 0, "R7 irq not yet", 64'(irq_o), 0);
    @(negedge clk);
    #1 chk(irq_o == 1 && irq_edge_o == 1, "R7 irq rise with pulse", {62'd0, irq_o, irq_edge_o}, 3);
    @(negedge clk);
    #1 chk(irq_o == 1 && irq_edge_o == 0, "R7 pulse one cycle", {62'd0, irq_o, irq_edge_o}, 2);
    reg_chk(12'h830, 32'h20, "R3 vector 5");
    msi(TGT, 32'd255, fv, fa, fd);
    reg_chk(12'h884, 32'h8000_0000, "R3 vector 255");
    msi(TGT, 32'd70, fv, fa, fd);
    reg_chk(12'h830 + 12'd24, 32'h0, "R3 disabled vector 70");
  endtask

  task automatic t_clear();
    reg_wr(12'h830, 32'h0);
    reg_chk(12'h830, 32'h20, "R4 zero leaves bit");
    reg_wr(12'h830, 32'h20);
    reg_wr(12'h884, 32'h8000_0000);
    reg_chk(12'h830, 32'h0, "R4 clear group0");
    reg_chk(12'h884, 32'h0, "R4 clear group7");
    #1 chk(irq_o == 0, "R7 irq falls", 64'(irq_o), 0);
  endtask

  task automatic t_masked();
    bit fv; logic [63:0] fa; logic [31:0] fd;
    msi(TGT, 32'd40, fv, fa, fd);
    @(negedge clk);
    @(negedge clk);
    #1 chk(irq_o == 0 && irq_edge_o == 0, "R10 masked no irq", {62'd0, irq_o, irq_edge_o}, 0);
    reg_chk(12'h83C, 32'h100, "R10 masked held");
  endtask

  task automatic t_race();
    bit fv; logic [63:0] fa; logic [31:0] fd;
    msi(TGT, 32'd3, fv, fa, fd);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = 12'h830; reg_wdata_i = 32'h8;
    wr_valid_i = 1'b1; wr_addr_i = TGT; wr_data_i = 32'd3;
    @(negedge clk);
    reg_wr_i = 1'b0; wr_valid_i = 1'b0;
    reg_chk(12'h830, 32'h8, "R5 capture wins same bit");
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = 12'h830; reg_wdata_i = 32'h8;
    wr_valid_i = 1'b1; wr_addr_i = TGT; wr_data_i = 32'd4;
    @(negedge clk);
    reg_wr_i = 1'b0; wr_valid_i = 1'b0;
    reg_chk(12'h830, 32'h10, "R5 clear and capture other bit");
  endtask

  task automatic t_range_fwd();
    bit fv; logic [63:0] fa; logic [31:0] fd;
    msi(TGT, 32'd256, fv, fa, fd);
    chk(fv == 0, "R8 out of range not forwarded", 64'(fv), 0);
    reg_chk(12'h830, 32'h10, "R8 out of range ignored");
    msi({32'h1, TGT[31:0]}, 32'd9, fv, fa, fd);
    chk(fv == 1, "R9 miss forwarded", 64'(fv), 1);
    chk(fa == {32'h1, TGT[31:0]}, "R9 fwd addr", fa, {32'h1, TGT[31:0]});
    chk(fd == 32'd9, "R9 fwd data", 64'(fd), 9);
    reg_chk(12'h830, 32'h10, "R9 miss sets nothing");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_config();
    t_capture();
    t_clear();
    t_masked();
    t_race();
    t_range_fwd();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule